// File: doc/BRIEF.md
# Serial SAR Converter Interface Controller

This block is the host-side master for a single-channel serial successive-approximation converter. It drives the converter's active-low chip-select and its serial clock, and it shifts in the converter's data line. The serial clock comes from the system clock through a divider. A frame opens when chip-select falls. The number of serial-clock falling edges seen before chip-select rises decides what the converter does next: it completes a conversion, it drops an aborted conversion but stays powered, or it goes into power-down.

A one-cycle request with a command bit starts either a full conversion or a short power-down frame. An abort input cuts any frame short. The controller keeps its own view of whether the converter is powered down. When a conversion is asked for while the converter is believed asleep, the controller first sends an unreported wake-up frame, waits the quiet time, and then sends the real conversion. Results are delivered as a 14-bit word with a one-cycle valid strobe. Aborted frames that left the converter powered are flagged with their own strobe.

Top module: `adc_serial_ctl`

## Requirements
- R1: While reset is applied and right after it, `adc_cs_n` and `adc_sclk` are high, `busy`, `res_valid` and `res_abort` are low, and `pd_state` is 0 (converter assumed powered).
- R2: A conversion frame holds `adc_cs_n` low while exactly 16 `adc_sclk` falling edges occur. `adc_sclk` is high whenever `adc_cs_n` is high, and it falls only while `adc_cs_n` is low. Each half period of `adc_sclk` lasts CLK_DIV system cycles, so consecutive falling edges are 2*CLK_DIV cycles apart.
- R3: The bit present before the first falling edge (the leading zero) is discarded. Bits are sampled on the rising edges that follow falling edges 1 to 14 and are assembled MSB first into `res_data`. `res_valid` pulses for one cycle, in the cycle in which `adc_cs_n` has just returned high after a full reported frame.
- R4: `req_valid` with `req_pwrdn`=0 requests a conversion, and with `req_pwrdn`=1 requests power-down. A request accepted in idle drives `adc_cs_n` low and `busy` high in the next cycle. `busy` stays high until the quiet time after the last frame has run out. Requests made while `busy` is high are ignored.
- R5: Between the end of one frame and the start of the next, `adc_cs_n` stays high for at least QUIET_CYC system cycles.
- R6: A power-down request produces a frame of exactly PD_EDGES falling edges (PD_EDGES is below 10). After it `pd_state` is 1 and `res_valid` does not pulse.
- R7: A conversion request while `pd_state` is 1 first runs a full 16-edge wake-up frame with no `res_valid`, which clears `pd_state`. After the quiet time it runs a second full frame, whose result is reported.
- R8: `abort` during a frame after 10 to 15 falling edges releases `adc_cs_n` in the next cycle and pulses `res_abort`. `res_valid` does not pulse and `pd_state` becomes 0.
- R9: `abort` during a frame after fewer than 10 falling edges releases `adc_cs_n` and sets `pd_state` to 1, with neither `res_abort` nor `res_valid`. A pending conversion after a wake-up frame is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | One-cycle request strobe, taken only when idle |
| req_pwrdn | input | 1 | Command with the request: 0 conversion, 1 power-down |
| abort | input | 1 | Ends the current frame at once |
| busy | output | 1 | Controller is framing or waiting out the quiet time |
| res_data | output | 14 | Last captured conversion word |
| res_valid | output | 1 | One-cycle strobe for a reported result |
| res_abort | output | 1 | One-cycle strobe for a frame aborted while the converter stayed powered |
| pd_state | output | 1 | Converter believed powered down |
| adc_cs_n | output | 1 | Converter chip-select, active low |
| adc_sclk | output | 1 | Converter serial clock, idles high |
| adc_sdata | input | 1 | Converter serial data |

## Verification
The hardest cases to reach are aborts that land on a chosen falling-edge count, above all an abort during the hidden wake-up frame, which must also cancel the conversion queued behind it. The bench models the converter. It counts serial-clock falling edges as they happen, waits until a chosen count is reached, and then raises `abort` in the next low clock phase. This places the abort at counts 5 and 12 in a normal frame and at count 4 in a wake-up frame. Data capture is swept over walking ones and a stride sequence of 14-bit words.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_QUIET = 2'd2
  } ctl_state_t;

endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    tick   = run && (cnt_q == CNT_LAST);
    cnt_en = 1'b1;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  generate
    if (DIV > 1) begin : g_spacing
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
  parameter int RES_W = 14,
  parameter int EW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sample,
  input  logic [EW-1:0]    edge_idx,
  input  logic             sdata,
  output logic [RES_W-1:0] data
);

  localparam logic [EW-1:0] LAST_BIT = EW'(RES_W);

  logic [RES_W-1:0] data_q, data_d;
  logic             in_window;
  logic             data_en;

  always_comb begin
    in_window = (edge_idx != '0) && (edge_idx <= LAST_BIT);
    data_en   = clr || (sample && in_window);
    if (clr) data_d = '0;
    else     data_d = {data_q[RES_W-2:0], sdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign data = data_q;

  a_r3_hold_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !(sample && in_window)) |=> $stable(data_q));

endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
  import adc_ctl_pkg::*;
#(
  parameter int FRAME_EDGES   = 16,
  parameter int MIN_PWR_EDGES = 10,
  parameter int PD_EDGES      = 4,
  parameter int QUIET_CYC     = 20,
  parameter int EW            = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_pwrdn,
  input  logic          abort,
  input  logic          tick,
  output logic          run,
  output logic          sample,
  output logic          frame_start,
  output logic [EW-1:0] edge_cnt,
  output logic          cs_n,
  output logic          sclk,
  output logic          busy,
  output logic          res_valid,
  output logic          res_abort,
  output logic          pd_state
);

  localparam int QW = (QUIET_CYC > 1) ? $clog2(QUIET_CYC) : 1;
  localparam logic [EW-1:0] FULL_E = EW'(FRAME_EDGES);
  localparam logic [EW-1:0] PD_E   = EW'(PD_EDGES);
  localparam logic [EW-1:0] MIN_E  = EW'(MIN_PWR_EDGES);
  localparam logic [QW-1:0] Q_LAST = QW'(QUIET_CYC - 1);

  ctl_state_t    state_q, state_d;
  logic          cs_n_q, cs_n_d;
  logic          sclk_q, sclk_d;
  logic [EW-1:0] edge_q, edge_d;
  logic [EW-1:0] tgt_q, tgt_d;
  logic          dummy_q, dummy_d;
  logic          pend_q, pend_d;
  logic [QW-1:0] qcnt_q, qcnt_d;
  logic          pd_q, pd_d;
  logic          rv_q, rv_d;
  logic          ra_q, ra_d;
  logic          start;

  always_comb begin
    state_d = state_q;
    cs_n_d  = cs_n_q;
    sclk_d  = sclk_q;
    edge_d  = edge_q;
    tgt_d   = tgt_q;
    dummy_d = dummy_q;
    pend_d  = pend_q;
    qcnt_d  = qcnt_q;
    pd_d    = pd_q;
    rv_d    = 1'b0;
    ra_d    = 1'b0;
    start   = 1'b0;

    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          start = 1'b1;
          if (req_pwrdn) begin
            tgt_d   = PD_E;
            dummy_d = 1'b0;
            pend_d  = 1'b0;
          end else begin
            tgt_d   = FULL_E;
            dummy_d = pd_q;
            pend_d  = pd_q;
          end
        end
      end

      ST_FRAME: begin
        if (abort) begin
          cs_n_d  = 1'b1;
          sclk_d  = 1'b1;
          state_d = ST_QUIET;
          qcnt_d  = '0;
          pend_d  = 1'b0;
          if (edge_q < MIN_E) begin
            pd_d = 1'b1;
          end else begin
            pd_d = 1'b0;
            ra_d = 1'b1;
          end
        end else if (tick) begin
          sclk_d = ~sclk_q;
          if (sclk_q) begin
            edge_d = edge_q + 1'b1;
          end else if (edge_q == tgt_q) begin
            cs_n_d  = 1'b1;
            state_d = ST_QUIET;
            qcnt_d  = '0;
            if (tgt_q == FULL_E) begin
              pd_d = 1'b0;
              rv_d = ~dummy_q;
            end else begin
              pd_d = 1'b1;
            end
          end
        end
      end

      ST_QUIET: begin
        if (qcnt_q == Q_LAST) begin
          if (pend_q) begin
            start   = 1'b1;
            tgt_d   = FULL_E;
            dummy_d = 1'b0;
            pend_d  = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          qcnt_d = qcnt_q + 1'b1;
        end
      end

      default: state_d = ST_IDLE;
    endcase

    if (start) begin
      state_d = ST_FRAME;
      cs_n_d  = 1'b0;
      sclk_d  = 1'b1;
      edge_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b1;
      edge_q  <= '0;
      tgt_q   <= '0;
      dummy_q <= 1'b0;
      pend_q  <= 1'b0;
      qcnt_q  <= '0;
      pd_q    <= 1'b0;
      rv_q    <= 1'b0;
      ra_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_n_q  <= cs_n_d;
      sclk_q  <= sclk_d;
      edge_q  <= edge_d;
      tgt_q   <= tgt_d;
      dummy_q <= dummy_d;
      pend_q  <= pend_d;
      qcnt_q  <= qcnt_d;
      pd_q    <= pd_d;
      rv_q    <= rv_d;
      ra_q    <= ra_d;
    end
  end

  assign run         = (state_q == ST_FRAME);
  assign sample      = run && tick && !sclk_q && !abort;
  assign frame_start = start;
  assign edge_cnt    = edge_q;
  assign cs_n        = cs_n_q;
  assign sclk        = sclk_q;
  assign busy        = (state_q != ST_IDLE);
  assign res_valid   = rv_q;
  assign res_abort   = ra_q;
  assign pd_state    = pd_q;

  a_r2_sclk_low_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_q |-> !cs_n_q);
  a_r2_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    edge_q <= FULL_E);
  a_r4_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_q |-> busy);
  a_r5_released_in_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_QUIET) |-> cs_n_q);
  a_r6_pd_moves_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_q) |-> $rose(cs_n_q));
  a_r3_valid_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |-> $rose(cs_n_q));
  a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |=> !rv_q);
  a_r8_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rv_q && ra_q));

endmodule

// File: rtl/adc_serial_ctl.sv
module adc_serial_ctl #(
  parameter int CLK_DIV       = 4,
  parameter int QUIET_CYC     = 20,
  parameter int PD_EDGES      = 4,
  parameter int MIN_PWR_EDGES = 10,
  parameter int RES_W         = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_pwrdn,
  input  logic             abort,
  output logic             busy,
  output logic [RES_W-1:0] res_data,
  output logic             res_valid,
  output logic             res_abort,
  output logic             pd_state,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  input  logic             adc_sdata
);

  localparam int FRAME_EDGES = RES_W + 2;
  localparam int EW          = $clog2(FRAME_EDGES + 1);

  logic [1:0]    rst_pipe_q;
  logic          rst_int_n;
  logic          run, tick, sample, frame_start;
  logic [EW-1:0] edge_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  adc_sclk_div #(
    .DIV (CLK_DIV)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (run),
    .tick  (tick)
  );

  adc_frame_fsm #(
    .FRAME_EDGES   (FRAME_EDGES),
    .MIN_PWR_EDGES (MIN_PWR_EDGES),
    .PD_EDGES      (PD_EDGES),
    .QUIET_CYC     (QUIET_CYC),
    .EW            (EW)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .req_pwrdn   (req_pwrdn),
    .abort       (abort),
    .tick        (tick),
    .run         (run),
    .sample      (sample),
    .frame_start (frame_start),
    .edge_cnt    (edge_cnt),
    .cs_n        (adc_cs_n),
    .sclk        (adc_sclk),
    .busy        (busy),
    .res_valid   (res_valid),
    .res_abort   (res_abort),
    .pd_state    (pd_state)
  );

  adc_rx_shift #(
    .RES_W (RES_W),
    .EW    (EW)
  ) u_rx (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .clr      (frame_start),
    .sample   (sample),
    .edge_idx (edge_cnt),
    .sdata    (adc_sdata),
    .data     (res_data)
  );

  a_r9_no_strobe_when_asleep: assert property (@(posedge clk) disable iff (!rst_int_n)
    pd_state |-> (!res_valid && !res_abort));

endmodule

// File: tb/adc_serial_ctl_tb.sv
module adc_serial_ctl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int QUIET      = 5;
  localparam int PDE        = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_pwrdn, abort;
  logic        busy, res_valid, res_abort, pd_state;
  logic [13:0] res_data;
  logic        adc_cs_n, adc_sclk;
  logic        adc_sdata;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_ctl #(
    .CLK_DIV   (DIV),
    .QUIET_CYC (QUIET),
    .PD_EDGES  (PDE)
  ) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_pwrdn (req_pwrdn),
    .abort     (abort),
    .busy      (busy),
    .res_data  (res_data),
    .res_valid (res_valid),
    .res_abort (res_abort),
    .pd_state  (pd_state),
    .adc_cs_n  (adc_cs_n),
    .adc_sclk  (adc_sclk),
    .adc_sdata (adc_sdata)
  );

  // converter model and monitors
  logic [13:0] model_val = '0;
  int frame_fe = 0, last_fe = 0, frames = 0;
  int nvalid = 0, nabort = 0;
  logic [13:0] got = '0;
  int cyc = 0, last_fall = 0, period_err = 0, stray_fall = 0;
  int hi_run = 0, min_gap = 1000000;
  bit seen_frame = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge adc_cs_n or negedge adc_sclk) begin
    if (!adc_sclk) begin
      if (adc_cs_n) stray_fall = stray_fall + 1;
      else begin
        if (frame_fe > 0 && (cyc - last_fall) != 2*DIV) period_err = period_err + 1;
        last_fall = cyc;
        frame_fe  = frame_fe + 1;
        adc_sdata = (frame_fe >= 1 && frame_fe <= 14) ? model_val[14 - frame_fe] : 1'b0;
      end
    end else begin
      frame_fe  = 0;
      adc_sdata = 1'b0;
    end
  end

  always @(posedge adc_cs_n) begin
    if (rst_n === 1'b1) begin
      last_fe = frame_fe;
      frames  = frames + 1;
    end
  end

  always @(negedge clk) begin
    if (res_valid === 1'b1) begin nvalid = nvalid + 1; got = res_data; end
    if (res_abort === 1'b1) nabort = nabort + 1;
    if (adc_cs_n === 1'b1) hi_run = hi_run + 1;
    else begin
      if (hi_run > 0 && seen_frame && hi_run < min_gap) min_gap = hi_run;
      if (hi_run > 0) seen_frame = 1;
      hi_run = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    nvalid = 0; nabort = 0; frames = 0;
  endtask

  task automatic issue(input logic [13:0] v, input bit pd);
    while (busy) @(negedge clk);
    model_val = v;
    clear_counts();
    req_valid = 1'b1; req_pwrdn = pd;
    @(negedge clk);
    req_valid = 1'b0; req_pwrdn = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic abort_at(input int n);
    while (frame_fe < n) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(adc_cs_n == 1'b1, "R8/R9 cs released after abort", adc_cs_n, 1);
    wait_idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_pwrdn = 1'b0; abort = 1'b0; adc_sdata = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(adc_cs_n && adc_sclk && !busy && !res_valid && !res_abort && !pd_state,
        "R1 reset outputs", {adc_cs_n, adc_sclk, busy, res_valid, res_abort, pd_state}, 6'b110000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(adc_cs_n && adc_sclk && !busy && !pd_state, "R1 after release",
        {adc_cs_n, adc_sclk, busy, pd_state}, 4'b1100);

    // R4 acceptance timing
    issue(14'h2AAA, 1'b0);
    chk(busy == 1'b1 && adc_cs_n == 1'b0, "R4 busy and select after accept", {busy, adc_cs_n}, 2'b10);
    // R4 request while busy is ignored
    @(negedge clk);
    req_valid = 1'b1; req_pwrdn = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; req_pwrdn = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    chk(frames == 1 && pd_state == 1'b0, "R4 request while busy ignored", frames, 1);
    chk(got == 14'h2AAA && nvalid == 1, "R3 first word", got, 14'h2AAA);

    // R2/R3 sweep: walking ones then stride sequence
    for (int i = 0; i < 14; i++) begin
      issue(14'(1 << i), 1'b0);
      wait_idle();
      chk(nvalid == 1 && got == 14'(1 << i), "R3 walking one", got, 1 << i);
      chk(last_fe == 16, "R2 falling edges per frame", last_fe, 16);
    end
    for (int i = 0; i < 40; i++) begin
      logic [13:0] v;
      v = 14'((i * 16'h2F1 + 16'h13) & 16'h3FFF);
      issue(v, 1'b0);
      wait_idle();
      chk(nvalid == 1 && got == v, "R3 stride word", got, v);
    end
    issue(14'h3FFF, 1'b0); wait_idle();
    chk(got == 14'h3FFF, "R3 all ones", got, 14'h3FFF);
    issue(14'h0000, 1'b0); wait_idle();
    chk(got == 14'h0000 && nvalid == 1, "R3 all zeros", got, 0);

    // R5 back-to-back requests held high
    clear_counts();
    req_valid = 1'b1; req_pwrdn = 1'b0;
    while (frames < 2) @(negedge clk);
    req_valid = 1'b0;
    wait_idle();

    // R6 power-down frame
    issue(14'h1234, 1'b1);
    wait_idle();
    chk(last_fe == PDE, "R6 power-down edge count", last_fe, PDE);
    chk(pd_state == 1'b1 && nvalid == 0, "R6 asleep and no result", {pd_state, nvalid[0]}, 2'b10);

    // R7 wake-up then conversion
    issue(14'h1B5E, 1'b0);
    wait_idle();
    chk(frames == 2, "R7 two frames", frames, 2);
    chk(nvalid == 1 && got == 14'h1B5E, "R7 reported result", got, 14'h1B5E);
    chk(pd_state == 1'b0, "R7 awake", pd_state, 0);

    // R8 abort between 10 and 15
    issue(14'h0F0F, 1'b0);
    abort_at(12);
    chk(nabort == 1 && nvalid == 0, "R8 abort strobe only", nabort, 1);
    chk(pd_state == 1'b0 && last_fe == 12, "R8 stays powered", last_fe, 12);

    // R9 abort below 10
    issue(14'h0F0F, 1'b0);
    abort_at(5);
    chk(pd_state == 1'b1 && nabort == 0 && nvalid == 0, "R9 early abort sleeps", pd_state, 1);

    // R9 abort inside the wake-up frame cancels the queued conversion
    issue(14'h0ABC, 1'b0);
    abort_at(4);
    repeat (QUIET + 4) @(negedge clk);
    chk(frames == 1 && nvalid == 0 && pd_state == 1'b1, "R9 queued conversion cancelled", frames, 1);

    issue(14'h3C3C, 1'b0);
    wait_idle();
    chk(frames == 2 && got == 14'h3C3C && !pd_state, "R7 wake after cancelled wake", got, 14'h3C3C);

    chk(min_gap >= QUIET, "R5 minimum release time", min_gap, QUIET);
    chk(period_err == 0, "R2 serial clock period", period_err, 0);
    chk(stray_fall == 0, "R2 no clock edge while released", stray_fall, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule